// File: doc/BRIEF.md
# Indirect PHY Management Register File

This block holds a small set of PHY management registers that a host cannot address directly. The host reaches them through a four-slot window: a command slot, an index slot and the two bytes of a 16-bit data holding register. To read a PHY register, the host writes the register number into the index slot. It then writes a read command into the command slot and, once the block is idle, collects the value from the two data bytes. To write a PHY register, the host loads the two data bytes, sets the index and issues a write command.

Three PHY registers hold state: the basic control register, the advertisement register and a vendor configuration register. Each applies its own write rules: a self-clearing soft-reset bit, a bit forced to zero, or a fully writable field. The status register returns a fixed capability word. The two identifier registers return constants set by parameters. Every other index reads as zero and has no storage.

Each command takes two clock edges. The first edge accepts the command and raises a busy flag. The second edge performs the transfer and drops the flag.

Top module: `phy_mgmt_regfile`

## Requirements
- R1: After reset the index slot and both data bytes read 0x00, the command slot reads 0x00, and the PHY registers hold their defaults: control 0x3100, advertisement 0x01E1, configuration 0x0410.
- R2: Only the low 6 bits of the index slot select the PHY register, so index 0x44 addresses register 4. The index slot reads back all 8 written bits.
- R3: A command byte with bit 2 or bit 3 set is a read, even if bit 1 is also set. A command byte with bit 1 set and bits 2 and 3 clear is a write.
- R4: A write to the data low slot (window select 2) or the data high slot (select 3) replaces only that byte of the 16-bit holding register.
- R5: A command raises busy (bit 7 of the command slot) for exactly one cycle. After that the result is visible and busy reads 0. A command written while busy is dropped.
- R6: The basic control register (index 0) never stores bit 15. A write with bit 15 set restores all three stateful registers to their defaults.
- R7: The advertisement register (index 4) stores all 16 written bits.
- R8: The configuration register (index 0x10) stores the written value with bit 3 forced to 0.
- R9: The status register (index 1) always reads 0x782D, and writes to it have no effect.
- R10: Index 2 reads parameter PHY_ID_HI (default 0x0181) and index 3 reads PHY_ID_LO (default 0xB8A0). Any index other than 0, 1, 2, 3, 4 or 0x10 reads 0x0000, and writes to those indices are ignored.
- R11: A command byte with bits 1 to 3 all clear starts nothing. Busy stays 0 and the holding register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Write strobe for the selected window slot |
| host_sel | input | 2 | Window slot: 0 command, 1 index, 2 data low, 3 data high |
| host_wdata | input | 8 | Write byte |
| host_rdata | output | 8 | Read byte of the selected slot (combinational) |

## Verification
The bench targets the command-bit priority. It sends the combined byte 0x0A, which a design with the wrong priority would treat as a write, overwriting the advertisement register with stale holding data. It checks the masked bits on the control and configuration registers, and it checks soft reset of all three registers together; a design that stored the reset bit, or that reset only the control register, returns the wrong words. It also checks index aliasing above 6 bits, byte-wise holding updates, and the single-cycle busy window. An off-by-one pipeline would show busy for zero or two cycles, or would return the data before the second edge.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;
   localparam int IDX_BASIC  = 0;
   localparam int IDX_STATUS = 1;
   localparam int IDX_ID_HI  = 2;
   localparam int IDX_ID_LO  = 3;
   localparam int IDX_ADV    = 4;
   localparam int IDX_CFG    = 16;

   localparam logic [15:0] BASIC_RST  = 16'h3100;
   localparam logic [15:0] ADV_RST    = 16'h01E1;
   localparam logic [15:0] CFG_RST    = 16'h0410;
   localparam logic [15:0] STATUS_VAL = 16'h782D;

   localparam int BASIC_RST_BIT = 15;
   localparam int CFG_ZERO_BIT  = 3;

   typedef enum logic [1:0] {
      SLOT_CMD  = 2'd0,
      SLOT_IDX  = 2'd1,
      SLOT_DLO  = 2'd2,
      SLOT_DHI  = 2'd3
   } slot_e;
endpackage

// File: rtl/phy_cmd_ctrl.sv
module phy_cmd_ctrl (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_wr,
   input  logic [3:1] cmd_bits,
   output logic       busy,
   output logic       exec_rd,
   output logic       exec_wr
);
   logic busy_q;
   logic is_rd_q;
   logic want_rd;
   logic want_wr;

   assign want_rd = cmd_bits[2] | cmd_bits[3];
   assign want_wr = cmd_bits[1] & ~want_rd;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         is_rd_q <= 1'b0;
      end else if (busy_q) begin
         busy_q  <= 1'b0;
      end else if (cmd_wr && (want_rd || want_wr)) begin
         busy_q  <= 1'b1;
         is_rd_q <= want_rd;
      end
   end

   assign busy    = busy_q;
   assign exec_rd = busy_q & is_rd_q;
   assign exec_wr = busy_q & ~is_rd_q;
endmodule

// File: rtl/phy_reg_bank.sv
module phy_reg_bank
   import phy_mgmt_pkg::*;
#(
   parameter int          IDX_W     = 6,
   parameter int          DATA_W    = 16,
   parameter bit          ID_EN     = 1'b1,
   parameter logic [15:0] PHY_ID_HI = 16'h0181,
   parameter logic [15:0] PHY_ID_LO = 16'hB8A0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  idx,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] basic_q, adv_q, cfg_q;
   logic [DATA_W-1:0] id_hi, id_lo;
   logic              soft_rst;

   generate
      if (ID_EN) begin : g_id
         assign id_hi = PHY_ID_HI;
         assign id_lo = PHY_ID_LO;
      end else begin : g_no_id
         assign id_hi = '0;
         assign id_lo = '0;
      end
   endgenerate

   assign soft_rst = wr_en && (int'(idx) == IDX_BASIC) && wr_data[BASIC_RST_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n || soft_rst) begin
         basic_q <= BASIC_RST;
         adv_q   <= ADV_RST;
         cfg_q   <= CFG_RST;
      end else if (wr_en) begin
         case (int'(idx))
            IDX_BASIC: begin
               basic_q                <= wr_data;
               basic_q[BASIC_RST_BIT] <= 1'b0;
            end
            IDX_ADV: adv_q <= wr_data;
            IDX_CFG: begin
               cfg_q               <= wr_data;
               cfg_q[CFG_ZERO_BIT] <= 1'b0;
            end
            default: ;
         endcase
      end
   end

   always_comb begin
      case (int'(idx))
         IDX_BASIC:  rd_data = basic_q;
         IDX_STATUS: rd_data = STATUS_VAL;
         IDX_ID_HI:  rd_data = id_hi;
         IDX_ID_LO:  rd_data = id_lo;
         IDX_ADV:    rd_data = adv_q;
         IDX_CFG:    rd_data = cfg_q;
         default:    rd_data = '0;
      endcase
   end
endmodule

// File: rtl/phy_mgmt_regfile.sv
module phy_mgmt_regfile
   import phy_mgmt_pkg::*;
#(
   parameter int          WIN_W     = 8,
   parameter int          IDX_W     = 6,
   parameter int          DATA_W    = 16,
   parameter bit          ID_EN     = 1'b1,
   parameter logic [15:0] PHY_ID_HI = 16'h0181,
   parameter logic [15:0] PHY_ID_LO = 16'hB8A0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             host_wr,
   input  logic [1:0]       host_sel,
   input  logic [WIN_W-1:0] host_wdata,
   output logic [WIN_W-1:0] host_rdata
);
   localparam int HALF_W = DATA_W / 2;

   generate
      if (DATA_W != 2 * WIN_W) begin : g_bad_data
         $error("DATA_W must equal two window bytes");
      end
      if (IDX_W > WIN_W || IDX_W < 5) begin : g_bad_idx
         $error("IDX_W must lie between 5 and WIN_W");
      end
   endgenerate

   logic [WIN_W-1:0]  addr_q;
   logic [DATA_W-1:0] data_q;
   logic [IDX_W-1:0]  idx;
   logic [DATA_W-1:0] bank_rd;
   logic              busy, exec_rd, exec_wr;
   logic              cmd_wr;

   assign idx    = addr_q[IDX_W-1:0];
   assign cmd_wr = host_wr && (host_sel == SLOT_CMD);

   phy_cmd_ctrl u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd_wr   (cmd_wr),
      .cmd_bits (host_wdata[3:1]),
      .busy     (busy),
      .exec_rd  (exec_rd),
      .exec_wr  (exec_wr)
   );

   phy_reg_bank #(
      .IDX_W     (IDX_W),
      .DATA_W    (DATA_W),
      .ID_EN     (ID_EN),
      .PHY_ID_HI (PHY_ID_HI),
      .PHY_ID_LO (PHY_ID_LO)
   ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .idx     (idx),
      .wr_en   (exec_wr),
      .wr_data (data_q),
      .rd_data (bank_rd)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
         data_q <= '0;
      end else begin
         if (host_wr && host_sel == SLOT_IDX) addr_q <= host_wdata;
         if (exec_rd) begin
            data_q <= bank_rd;
         end else if (host_wr && host_sel == SLOT_DLO) begin
            data_q[HALF_W-1:0] <= host_wdata;
         end else if (host_wr && host_sel == SLOT_DHI) begin
            data_q[DATA_W-1:HALF_W] <= host_wdata;
         end
      end
   end

   always_comb begin
      case (host_sel)
         SLOT_CMD: host_rdata = {busy, {(WIN_W-1){1'b0}}};
         SLOT_IDX: host_rdata = addr_q;
         SLOT_DLO: host_rdata = data_q[HALF_W-1:0];
         default:  host_rdata = data_q[DATA_W-1:HALF_W];
      endcase
   end
endmodule

// File: rtl/phy_mgmt_checker.sv
module phy_mgmt_checker #(
   parameter int WIN_W  = 8,
   parameter int IDX_W  = 6,
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              host_wr,
   input logic [1:0]        host_sel,
   input logic [WIN_W-1:0]  host_wdata,
   input logic              busy,
   input logic              exec_rd,
   input logic [IDX_W-1:0]  idx,
   input logic [DATA_W-1:0] data_q
);
   p_busy_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !busy);

   p_cmd_starts_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && host_sel == 2'd0 && !busy && (|host_wdata[3:1])) |=> busy);

   p_idle_cmd_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && host_sel == 2'd0 && !busy && !(|host_wdata[3:1])) |=> !busy);

   p_hold_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!host_wr && !busy) |=> $stable(data_q));

   p_basic_bit15_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_rd && int'(idx) == 0) |=> !data_q[15]);

   p_cfg_bit3_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_rd && int'(idx) == 16) |=> !data_q[3]);

   p_status_const_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_rd && int'(idx) == 1) |=> data_q == 16'h782D);
endmodule

bind phy_mgmt_regfile phy_mgmt_checker #(
   .WIN_W  (WIN_W),
   .IDX_W  (IDX_W),
   .DATA_W (DATA_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .host_wr    (host_wr),
   .host_sel   (host_sel),
   .host_wdata (host_wdata),
   .busy       (busy),
   .exec_rd    (exec_rd),
   .idx        (idx),
   .data_q     (data_q)
);

// File: tb/tb_phy_mgmt_regfile.sv
module tb_phy_mgmt_regfile;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_wr = 1'b0;
   logic [1:0] host_sel = 2'd0;
   logic [7:0] host_wdata = 8'h00;
   logic [7:0] host_rdata;
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   phy_mgmt_regfile dut (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr),
      .host_sel(host_sel), .host_wdata(host_wdata), .host_rdata(host_rdata)
   );

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic slot_wr(input logic [1:0] s, input logic [7:0] v);
      @(negedge clk);
      host_wr = 1'b1; host_sel = s; host_wdata = v;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic slot_rd(input logic [1:0] s, output logic [7:0] v);
      host_sel = s;
      #1 v = host_rdata;
   endtask

   task automatic hold_rd(output logic [15:0] v);
      logic [7:0] lo, hi;
      slot_rd(2'd2, lo);
      slot_rd(2'd3, hi);
      v = {hi, lo};
   endtask

   // issue a command and wait for completion (two edges)
   task automatic command(input logic [7:0] c);
      slot_wr(2'd0, c);
      @(negedge clk);
   endtask

   task automatic phy_read(input logic [7:0] i, output logic [15:0] v);
      slot_wr(2'd1, i);
      command(8'h04);
      hold_rd(v);
   endtask

   task automatic phy_write(input logic [7:0] i, input logic [15:0] v);
      slot_wr(2'd2, v[7:0]);
      slot_wr(2'd3, v[15:8]);
      slot_wr(2'd1, i);
      command(8'h02);
   endtask

   task automatic t_reset;
      logic [7:0] b; logic [15:0] v;
      slot_rd(2'd0, b); check("R1 cmd slot", {8'h0, b}, 16'h0);
      slot_rd(2'd1, b); check("R1 index slot", {8'h0, b}, 16'h0);
      hold_rd(v);       check("R1 holding", v, 16'h0);
      phy_read(8'd0, v);  check("R1 basic default", v, 16'h3100);
      phy_read(8'd4, v);  check("R1 adv default", v, 16'h01E1);
      phy_read(8'd16, v); check("R1 cfg default", v, 16'h0410);
   endtask

   task automatic t_alias;
      logic [7:0] b; logic [15:0] v;
      phy_read(8'h44, v); check("R2 alias 0x44", v, 16'h01E1);
      slot_rd(2'd1, b);   check("R2 index readback", {8'h0, b}, 16'h0044);
   endtask

   task automatic t_bytes;
      logic [15:0] v;
      slot_wr(2'd2, 8'h12); slot_wr(2'd3, 8'h34);
      hold_rd(v); check("R4 both bytes", v, 16'h3412);
      slot_wr(2'd2, 8'h56);
      hold_rd(v); check("R4 low only", v, 16'h3456);
      slot_wr(2'd3, 8'h9A);
      hold_rd(v); check("R4 high only", v, 16'h9A56);
   endtask

   task automatic t_busy;
      logic [7:0] b; logic [15:0] v;
      slot_wr(2'd1, 8'd1);
      slot_wr(2'd0, 8'h04);
      slot_rd(2'd0, b); check("R5 busy high", {8'h0, b}, 16'h0080);
      @(negedge clk);
      slot_rd(2'd0, b); check("R5 busy low after", {8'h0, b}, 16'h0000);
      hold_rd(v); check("R5 result ready", v, 16'h782D);
   endtask

   task automatic t_priority;
      logic [15:0] v;
      slot_wr(2'd2, 8'h55); slot_wr(2'd3, 8'h55);
      slot_wr(2'd1, 8'd4);
      command(8'h0A);
      hold_rd(v); check("R3 0x0A reads", v, 16'h01E1);
      slot_wr(2'd2, 8'h55); slot_wr(2'd3, 8'h55);
      command(8'h08);
      hold_rd(v); check("R3 0x08 reads", v, 16'h01E1);
      slot_wr(2'd2, 8'h55); slot_wr(2'd3, 8'h55);
      command(8'h02);
      phy_read(8'd4, v); check("R3 0x02 writes", v, 16'h5555);
   endtask

   task automatic t_idle_cmd;
      logic [7:0] b; logic [15:0] v;
      slot_wr(2'd2, 8'hC3); slot_wr(2'd3, 8'h3C);
      slot_wr(2'd0, 8'hF1);
      slot_rd(2'd0, b); check("R11 no busy", {8'h0, b}, 16'h0);
      @(negedge clk);
      hold_rd(v); check("R11 holding kept", v, 16'h3CC3);
   endtask

   task automatic t_regs;
      logic [15:0] v;
      phy_write(8'd4, 16'hABCD);
      phy_read(8'd4, v);  check("R7 adv full", v, 16'hABCD);
      phy_write(8'd0, 16'h70F0);
      phy_write(8'd0, 16'hF0F0);
      phy_read(8'd0, v);  check("R6 bit15 dropped", v, 16'h3100);
      phy_write(8'd0, 16'h70F0);
      phy_read(8'd0, v);  check("R6 basic write", v, 16'h70F0);
      phy_write(8'd16, 16'hFFFF);
      phy_read(8'd16, v); check("R8 cfg bit3", v, 16'hFFF7);
      phy_write(8'd4, 16'h1111);
      phy_write(8'd0, 16'h8000);
      phy_read(8'd0, v);  check("R6 soft reset basic", v, 16'h3100);
      phy_read(8'd4, v);  check("R6 soft reset adv", v, 16'h01E1);
      phy_read(8'd16, v); check("R6 soft reset cfg", v, 16'h0410);
      phy_write(8'd1, 16'h0000);
      phy_read(8'd1, v);  check("R9 status const", v, 16'h782D);
      phy_write(8'd2, 16'h0000);
      phy_read(8'd2, v);  check("R10 id hi", v, 16'h0181);
      phy_read(8'd3, v);  check("R10 id lo", v, 16'hB8A0);
      phy_write(8'd5, 16'hFFFF);
      phy_read(8'd5, v);  check("R10 unused idx", v, 16'h0000);
      phy_read(8'h3F, v); check("R10 idx 0x3F", v, 16'h0000);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_alias();
      t_bytes();
      t_busy();
      t_priority();
      t_idle_cmd();
      t_regs();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule